// File: doc/BRIEF.md
# Double-Buffered Multichannel DAC Register Interface

This block is the bus-side register file of a sixteen-channel, 12-bit analog output card on a byte-wide I/O bus. A five-bit switch input places a 32-byte window anywhere on a 10-bit address space. Each channel owns two consecutive bytes in that window. The even byte holds the low eight code bits and the odd byte holds the upper four. Both bytes land first in input latches. A channel's code reaches its output register only through a transfer.

Channels are grouped in pairs, and one group-select bit per pair picks the transfer style. In individual style, writing the upper nibble transfers the full code at once. In group style, that write only fills the latch. Every group-style channel then transfers together when any read lands inside the window. Each output register has a one-cycle update strobe that marks the cycle its new code appears, so the converters downstream can load in step. A wait-state request, gated by its own enable input, is raised while the window is being accessed.

Top module: `mchan_dac_regs`

## Requirements
- R1: An access counts only when bus address bits 9..5 equal `base_sel`. Writes and reads outside the window change no latch, no output code and no strobe.
- R2: A write to window offset 2n stores data bits 7..0 as code bits 7..0 of channel n (data bit 0 is the code LSB). On its own it leaves the output code and strobe of every channel unchanged.
- R3: When `pair_group[n/2]` is 0, a write to offset 2n+1 puts {data bits 3..0, held low byte} on `code_out[12n+11:12n]` in the cycle after the write. Data bits 7..4 are ignored.
- R4: When `pair_group[n/2]` is 1, a write to offset 2n+1 only loads the nibble latch. The output code and strobe of channel n stay unchanged.
- R5: A read at any window offset moves the latched 12-bit code of every group-style channel to its output, all in the same cycle after the read. Individual-style channels are not affected.
- R6: Each output register load raises that channel's `code_upd` bit for exactly one cycle, the same cycle the new code first appears. Channels loaded by one group read raise their bits together.
- R7: `bus_rdata` is 0xFF during a read inside the window and 0x00 at all other times.
- R8: `wait_req` is high exactly when `wait_en` is 1 and a read or write hits the window, in the same cycle.
- R9: While `rst_n` is low, all latches and output codes are zero and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | I/O address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data byte |
| base_sel | input | 5 | Window base, compared with address bits 9..5 |
| pair_group | input | 8 | Per channel pair: 1 = group transfer, 0 = individual |
| wait_en | input | 1 | Enables the wait-state request |
| wait_req | output | 1 | Wait-state request during window access |
| code_out | output | 192 | Channel n code in bits 12n+11..12n |
| code_upd | output | 16 | Per-channel one-cycle update strobe |

## Verification
Register loads take effect at the clock edge that samples the access. So the output code and its strobe are due one cycle after a write or read strobe, and the strobe must drop again one cycle after that. `bus_rdata` and `wait_req` are combinational and are due in the same cycle as the access. The bench drives each access on a falling edge. It checks the combinational results a moment later, before the rising edge, and checks the registered codes and strobes at the next falling edge, after the one register stage has loaded. A further falling edge confirms that each strobe has returned low.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
    localparam int BYTE_W      = 8;
    localparam int BUS_ADDR_W  = 10;
    localparam int DEF_NUM_CH  = 16;
    localparam int DEF_CODE_W  = 12;
    localparam logic [BYTE_W-1:0] RD_FILL = 8'hFF;
endpackage

// File: rtl/dacif_decode.sv
module dacif_decode #(
    parameter int ADDR_W = 10,
    parameter int NUM_CH = 16
) (
    input  logic [ADDR_W-1:0]                       addr,
    input  logic                                    wr,
    input  logic                                    rd,
    input  logic [ADDR_W-$clog2(NUM_CH)-2:0]        base_sel,
    output logic                                    hit,
    output logic                                    grp_commit,
    output logic [NUM_CH-1:0]                       wr_lo,
    output logic [NUM_CH-1:0]                       wr_hi
);
    localparam int CH_W  = $clog2(NUM_CH);
    localparam int OFF_W = CH_W + 1;

    logic in_win;

    assign in_win     = (addr[ADDR_W-1:OFF_W] == base_sel);
    assign hit        = in_win & (wr | rd);
    assign grp_commit = in_win & rd;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_sel
        logic ch_match;
        assign ch_match = in_win & wr & (addr[OFF_W-1:1] == CH_W'(n));
        assign wr_lo[n] = ch_match & ~addr[0];
        assign wr_hi[n] = ch_match &  addr[0];
    end
endmodule

// File: rtl/dacif_channel.sv
module dacif_channel #(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              grp_commit,
    input  logic              grp_mode,
    input  logic [7:0]        lo_data,
    input  logic [CODE_W-9:0] hi_data,
    output logic [CODE_W-1:0] code_o,
    output logic              upd_o
);
    localparam int HI_W = CODE_W - 8;

    typedef struct packed {
        logic [7:0]        lo;
        logic [HI_W-1:0]   hi;
        logic [CODE_W-1:0] code;
        logic              upd;
    } ch_state_t;

    ch_state_t st_d, st_q;

    always_comb begin
        logic            commit;
        logic [HI_W-1:0] hi_src;
        st_d   = st_q;
        hi_src = wr_hi ? hi_data : st_q.hi;
        commit = grp_mode ? grp_commit : wr_hi;
        if (wr_lo) st_d.lo = lo_data;
        if (wr_hi) st_d.hi = hi_data;
        st_d.upd = commit;
        if (commit) st_d.code = {hi_src, st_q.lo};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign upd_o  = st_q.upd;

    // R2: a low-byte write alone leaves the output untouched
    a_r2_lo_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !(grp_mode && grp_commit)) |=> ($stable(code_o) && !upd_o));

    // R3: individual nibble write commits the joined code next cycle
    a_r3_indiv_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !grp_mode) |=> (upd_o && code_o == {$past(hi_data), $past(st_q.lo)}));

    // R4: group-style nibble write does not reach the output
    a_r4_grp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && grp_mode && !grp_commit) |=> ($stable(code_o) && !upd_o));

    // R5: group read moves the latched code
    a_r5_grp_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_commit && grp_mode && !wr_hi) |=>
            (upd_o && code_o == {$past(st_q.hi), $past(st_q.lo)}));

    // R6: no strobe without a cause
    a_r6_upd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hi && !grp_commit) |=> !upd_o);
endmodule

// File: rtl/mchan_dac_regs.sv
module mchan_dac_regs
    import dacif_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [BUS_ADDR_W-1:0]                       bus_addr,
    input  logic [BYTE_W-1:0]                           bus_wdata,
    input  logic                                        bus_wr,
    input  logic                                        bus_rd,
    output logic [BYTE_W-1:0]                           bus_rdata,
    input  logic [BUS_ADDR_W-$clog2(NUM_CH)-2:0]        base_sel,
    input  logic [NUM_CH/2-1:0]                         pair_group,
    input  logic                                        wait_en,
    output logic                                        wait_req,
    output logic [NUM_CH*CODE_W-1:0]                    code_out,
    output logic [NUM_CH-1:0]                           code_upd
);
    localparam int HI_W = CODE_W - BYTE_W;

    logic              hit;
    logic              grp_commit;
    logic [NUM_CH-1:0] wr_lo;
    logic [NUM_CH-1:0] wr_hi;

    dacif_decode #(
        .ADDR_W (BUS_ADDR_W),
        .NUM_CH (NUM_CH)
    ) u_dec (
        .addr       (bus_addr),
        .wr         (bus_wr),
        .rd         (bus_rd),
        .base_sel   (base_sel),
        .hit        (hit),
        .grp_commit (grp_commit),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        dacif_channel #(
            .CODE_W (CODE_W)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo      (wr_lo[n]),
            .wr_hi      (wr_hi[n]),
            .grp_commit (grp_commit),
            .grp_mode   (pair_group[n/2]),
            .lo_data    (bus_wdata),
            .hi_data    (bus_wdata[HI_W-1:0]),
            .code_o     (code_out[n*CODE_W +: CODE_W]),
            .upd_o      (code_upd[n])
        );
    end

    assign bus_rdata = (grp_commit) ? RD_FILL : '0;
    assign wait_req  = wait_en & hit;

    // R1: decoder selects at most one byte latch per cycle
    a_r1_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo, wr_hi}));

    // R5: strobes of one group read rise together, individual ones stay low
    a_r5_no_indiv_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> ($countones(code_upd) <= 2 * $countones(pair_group)));
endmodule

// File: tb/sim_mchan_dac_regs.sv
`timescale 1ns/1ps
module sim_mchan_dac_regs;
    localparam int NCH = 16;
    localparam int CW  = 12;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [9:0]     bus_addr;
    logic [7:0]     bus_wdata;
    logic           bus_wr;
    logic           bus_rd;
    logic [7:0]     bus_rdata;
    logic [4:0]     base_sel;
    logic [7:0]     pair_group;
    logic           wait_en;
    logic           wait_req;
    logic [NCH*CW-1:0] code_out;
    logic [NCH-1:0] code_upd;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mchan_dac_regs u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .base_sel   (base_sel),
        .pair_group (pair_group),
        .wait_en    (wait_en),
        .wait_req   (wait_req),
        .code_out   (code_out),
        .code_upd   (code_upd)
    );

    function automatic logic [CW-1:0] code_of(int ch);
        return code_out[ch*CW +: CW];
    endfunction

    task automatic check(string req, logic [191:0] act, logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one write cycle; returns after the registered result is visible
    task automatic bus_write(logic [9:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 codes", code_out, '0);
        check("R9 strobes", code_upd, '0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_individual;
        bus_write(10'h306, 8'hA5);
        check("R2 code unchanged", code_of(3), 12'h000);
        check("R2 no strobe", code_upd, '0);
        bus_write(10'h307, 8'hF7);
        check("R3 code joined", code_of(3), 12'h7A5);
        check("R6 strobe ch3 only", code_upd, 16'h0008);
        @(negedge clk);
        check("R6 strobe one cycle", code_upd, '0);
        bus_write(10'h31E, 8'h00);
        bus_write(10'h31F, 8'h1F);
        check("R3 last channel", code_of(15), 12'hF00);
    endtask

    task automatic t_outside;
        bus_write(10'h206, 8'h11);
        bus_write(10'h207, 8'h02);
        check("R1 outside write code", code_of(3), 12'h7A5);
        check("R1 outside write strobe", code_upd, '0);
        bus_write(10'h307, 8'h02);
        check("R1 outside lo not latched", code_of(3), 12'h2A5);
    endtask

    task automatic t_group;
        pair_group = 8'b0000_0100;
        bus_write(10'h308, 8'h12);
        bus_write(10'h309, 8'h03);
        bus_write(10'h30A, 8'hFF);
        bus_write(10'h30B, 8'hFC);
        check("R4 ch4 held", code_of(4), 12'h000);
        check("R4 ch5 held", code_of(5), 12'h000);
        check("R4 no strobe", code_upd, '0);
        // read outside window: no transfer
        @(negedge clk);
        bus_addr = 10'h1FF; bus_rd = 1'b1;
        #1 check("R7 outside rdata", bus_rdata, 8'h00);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R1 outside read no commit", code_of(4), 12'h000);
        // read inside window
        wait_en = 1'b1;
        @(negedge clk);
        bus_addr = 10'h31F; bus_rd = 1'b1;
        #1 check("R7 inside rdata", bus_rdata, 8'hFF);
        check("R8 wait on read", wait_req, 1'b1);
        @(negedge clk);
        bus_rd = 1'b0;
        check("R5 ch4 commit", code_of(4), 12'h312);
        check("R5 ch5 commit", code_of(5), 12'hCFF);
        check("R5 ch3 untouched", code_of(3), 12'h2A5);
        check("R6 group strobes", code_upd, 16'h0030);
        #1 check("R7 idle rdata", bus_rdata, 8'h00);
        @(negedge clk);
        check("R6 group strobes drop", code_upd, '0);
    endtask

    task automatic t_wait;
        @(negedge clk);
        bus_addr = 10'h300; bus_wdata = 8'h00; bus_wr = 1'b1; wait_en = 1'b1;
        #1 check("R8 wait on write", wait_req, 1'b1);
        bus_addr = 10'h2E0;
        #1 check("R8 outside no wait", wait_req, 1'b0);
        bus_addr = 10'h300; wait_en = 1'b0;
        #1 check("R8 disabled", wait_req, 1'b0);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R2 lo write ch0 quiet", code_upd, '0);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        base_sel = 5'b11000; pair_group = '0; wait_en = 1'b0;
        t_reset;
        t_individual;
        t_outside;
        t_group;
        t_wait;
        t_reset;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule